// File: doc/BRIEF.md
# I2C SCL clock waveform generator

This block produces the SCL timing for an I2C master from a fast peripheral clock. A single configuration word supplies a low-phase divider, a high-phase divider, a shared power-of-two exponent and an SDA hold field. Each half-period lasts `div * 2^exp + OFFSET` peripheral clock cycles. Because the low and high dividers are separate fields, the duty cycle can be made asymmetric. The generator drives an SCL pull-down enable. It marks every change of that drive with a one-cycle edge tick. After SCL falls it issues a strobe that tells the data path when SDA may change.

SCL is sampled back through `scl_i`. The high-phase count advances only while the line actually reads high, so a slave that holds SCL low stretches the high phase. The configuration word is captured when a low phase begins, so a write in the middle of a period never shortens the current half-period. When the enable input drops, SCL is released and the block idles. When the enable input rises, the block restarts with a fresh low phase.

Top module: `scl_clk_gen`

## Requirements
- R1: Configuration word fields are: bits 7:0 the low divider, bits 15:8 the high divider, bits 18:16 the exponent, bits 29:24 the hold field; the other bits are ignored. A low phase drives `scl_drive_low_o` high for exactly `low_div * 2^exp + OFFSET` cycles (OFFSET defaults to 4), including the case of a zero divider.
- R2: A high phase keeps SCL released for `high_div * 2^exp + OFFSET` cycles counted while `scl_i` reads high. It is independent of the low divider, so the two phases may differ in length.
- R3: An exponent field above EXP_MAX (default 5) is treated as EXP_MAX. For example, divider 255 with an exponent field of 7 gives 255*32+4 = 8164 cycles.
- R4: `sda_ok_o` pulses for exactly one cycle, `hold + 3` cycles after the first cycle of a low phase. A hold field of 0 gives a 3-cycle delay.
- R5: If `hold + 3` is not less than the low-phase length, no `sda_ok_o` pulse occurs in that period. `sda_ok_o` is never high outside a low phase.
- R6: `scl_edge_o` is high for one cycle in the first cycle after each change of `scl_drive_low_o`, and low otherwise.
- R7: While SCL is released and `scl_i` reads low, the high-phase count holds. Each stalled cycle lengthens the released time by one cycle.
- R8: The configuration word is sampled in the cycle a low phase starts. The low length, high length and hold delay of a period all come from that sample, and a change applies from the next low phase.
- R9: After reset, and from the cycle after `en_i` is sampled low, `scl_drive_low_o` is 0. `sda_ok_o` stays 0 and no further edge tick occurs while disabled.
- R10: In the cycle after `en_i` is sampled high from the idle state, a low phase starts: `scl_drive_low_o` and `scl_edge_o` are both 1, and the low phase has its full configured length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Generator enable |
| cfg_i | input | 32 | Configuration word (dividers, exponent, hold) |
| scl_i | input | 1 | Sampled SCL line level |
| scl_drive_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| scl_edge_o | output | 1 | One-cycle tick on each change of SCL drive |
| sda_ok_o | output | 1 | One-cycle strobe: SDA may change now |

## Verification
A corrupted phase counter or a stuck phase state shows as a half-period of the wrong length. That error appears at the very next edge tick, at most one half-period after the fault. A stale or missed configuration sample shows up one period later, as the wrong high or low length in the period after a word change. A hold timer that is misloaded or left running shows as a strobe at the wrong offset in the same low phase, or as a strobe where none is due. A stall input that is ignored shortens the released phase on the first stretched period.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int CFG_W    = 32;
  localparam int DIV_W    = 8;
  localparam int EXP_W    = 3;
  localparam int HOLD_W   = 6;
  localparam int LOW_LSB  = 0;
  localparam int HIGH_LSB = 8;
  localparam int EXP_LSB  = 16;
  localparam int HOLD_LSB = 24;
  localparam int HOLD_FIX = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_len_decode.sv
module scl_len_decode #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 5,
  parameter int OFFSET  = 4,
  parameter int CNT_W   = 13
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [CNT_W-1:0] len_o
);
  logic [EXP_W-1:0] exp_eff;

  generate
    if (EXP_MAX >= (2**EXP_W) - 1) begin : g_noclamp
      assign exp_eff = exp_i;
    end else begin : g_clamp
      assign exp_eff = (exp_i > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_i;
    end
  endgenerate

  assign len_o = (CNT_W'(div_i) << exp_eff) + CNT_W'(OFFSET);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             scl_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] high_len_i,
  output logic             start_o,
  output logic             drive_low_o,
  output logic             edge_o
);
  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edge_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_o = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (en_i) begin
          state_d = PH_LOW;
          cnt_d   = low_len_i - CNT_W'(1);
          start_o = 1'b1;
        end
      end
      PH_LOW: begin
        if (!en_i) begin
          state_d = PH_IDLE;
        end else if (cnt_q == '0) begin
          state_d = PH_HIGH;
          cnt_d   = high_len_i - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HIGH: begin
        if (!en_i) begin
          state_d = PH_IDLE;
        end else if (scl_i) begin
          // count only while the line really reads high (stretching)
          if (cnt_q == '0) begin
            state_d = PH_LOW;
            cnt_d   = low_len_i - CNT_W'(1);
            start_o = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      edge_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      edge_q  <= (state_d == PH_LOW) != (state_q == PH_LOW);
    end
  end

  assign drive_low_o = (state_q == PH_LOW);
  assign edge_o      = edge_q;

  AST_EDGE_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_low_o != $past(drive_low_o)) |-> edge_o); // R6
  AST_NO_EDGE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_low_o == $past(drive_low_o)) |-> !edge_o); // R6
  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !drive_low_o); // R9
  AST_START_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |=> drive_low_o); // R10
  AST_HOLD_WHILE_STRETCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_HIGH && en_i && !scl_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/scl_hold_timer.sv
module scl_hold_timer #(
  parameter int HOLD_W = 6,
  parameter int FIXED  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              in_low_i,
  output logic              sda_ok_o
);
  localparam int HT_W = $clog2((2**HOLD_W) + FIXED);

  logic            active_q;
  logic [HT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= HT_W'(hold_i) + HT_W'(FIXED);
    end else if (active_q) begin
      if (cnt_q == '0 || !in_low_i) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - HT_W'(1);
      end
    end
  end

  // strobe cancelled if the low phase ended first
  assign sda_ok_o = active_q && in_low_i && (cnt_q == '0);

  AST_STROBE_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_ok_o |-> in_low_i); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_ok_o |=> !sda_ok_o); // R4
endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
  import scl_gen_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int EXP_MAX = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             scl_i,
  output logic             scl_drive_low_o,
  output logic             scl_edge_o,
  output logic             sda_ok_o
);
  localparam int MAX_LEN = ((2**DIV_W) - 1) * (2**EXP_MAX) + OFFSET;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [DIV_W-1:0]  live_low, live_high, snap_high_q;
  logic [EXP_W-1:0]  live_exp, snap_exp_q;
  logic [HOLD_W-1:0] live_hold;
  logic [CNT_W-1:0]  low_len, high_len;
  logic              start;
  logic              unused_cfg;

  assign live_low   = cfg_i[LOW_LSB  +: DIV_W];
  assign live_high  = cfg_i[HIGH_LSB +: DIV_W];
  assign live_exp   = cfg_i[EXP_LSB  +: EXP_W];
  assign live_hold  = cfg_i[HOLD_LSB +: HOLD_W];
  assign unused_cfg = ^{cfg_i[CFG_W-1:HOLD_LSB+HOLD_W], cfg_i[HOLD_LSB-1:EXP_LSB+EXP_W]};

  // high phase uses the word captured when its low phase began
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_high_q <= '0;
      snap_exp_q  <= '0;
    end else if (start) begin
      snap_high_q <= live_high;
      snap_exp_q  <= live_exp;
    end
  end

  scl_len_decode #(
    .DIV_W(DIV_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .OFFSET(OFFSET), .CNT_W(CNT_W)
  ) i_low_dec (
    .div_i(live_low), .exp_i(live_exp), .len_o(low_len)
  );

  scl_len_decode #(
    .DIV_W(DIV_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .OFFSET(OFFSET), .CNT_W(CNT_W)
  ) i_high_dec (
    .div_i(snap_high_q), .exp_i(snap_exp_q), .len_o(high_len)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .scl_i      (scl_i),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .start_o    (start),
    .drive_low_o(scl_drive_low_o),
    .edge_o     (scl_edge_o)
  );

  scl_hold_timer #(.HOLD_W(HOLD_W), .FIXED(HOLD_FIX)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .hold_i  (live_hold),
    .in_low_i(scl_drive_low_o),
    .sda_ok_o(sda_ok_o)
  );

  AST_SNAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> ($stable(snap_high_q) && $stable(snap_exp_q))); // R8
  AST_START_ENTERS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (scl_drive_low_o && scl_edge_o)); // R10
endmodule

// File: tb/test_scl_clk_gen.sv
module test_scl_clk_gen;
  localparam int K_HOLD = 0, K_LOW = 1, K_HIGH = 2;

  typedef struct {
    int    kind;
    int    val;
    string req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic        scl_i;
  logic        drv, edg, sda_ok;

  int    n_tests = 0, n_fail = 0;
  item_t exp_q[$];
  bit    mon_on = 1'b0;
  int    stretch_amt = 0;
  int    str_cnt = 0;

  always #2 clk_i = ~clk_i;

  // slave model: optionally hold SCL low at the start of each high phase
  always @(posedge clk_i) begin
    if (drv && edg) str_cnt <= stretch_amt;
    else if (!drv && str_cnt > 0) str_cnt <= str_cnt - 1;
  end
  assign scl_i = !drv && (str_cnt == 0);

  scl_clk_gen i_scl_clk_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cfg_i(cfg_i), .scl_i(scl_i),
    .scl_drive_low_o(drv), .scl_edge_o(edg), .sda_ok_o(sda_ok)
  );

  function automatic logic [31:0] mk(int lo, int hi, int ex, int hd);
    return {2'b0, 6'(hd), 5'b0, 3'(ex), 8'(hi), 8'(lo)};
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push_period(int nl, int nh, int hoff, string tl, string th, string td);
    if (hoff >= 0) exp_q.push_back('{K_HOLD, hoff, td});
    exp_q.push_back('{K_LOW, nl, tl});
    exp_q.push_back('{K_HIGH, nh, th});
  endtask

  task automatic emit(int kind, int val);
    item_t it;
    if (exp_q.size() == 0) begin
      n_tests++; n_fail++;
      $display("FAIL R6: unexpected item kind %0d got %0d expected none", kind, val);
    end else begin
      it = exp_q.pop_front();
      chk(it.kind == kind, it.req, kind, it.kind);
      if (it.kind == kind) chk(it.val == val, it.req, val, it.val);
    end
  endtask

  // monitor: measures phase lengths and strobe offsets
  int  run = 0;
  bit  have = 1'b0;
  always @(negedge clk_i) begin
    if (!mon_on) begin
      have = 1'b0;
      run  = 0;
    end else begin
      if (edg) begin
        if (have) emit(drv ? K_HIGH : K_LOW, run);
        have = 1'b1;
        run  = 1;
      end else begin
        run++;
      end
      if (sda_ok) emit(K_HOLD, run - 1);
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    mon_on = 1'b0;
    en_i   = 1'b0;
  endtask

  task automatic wait_fall();
    do @(negedge clk_i); while (!(drv && edg));
  endtask

  task automatic seg_start(logic [31:0] w, int stretch);
    en_i = 1'b0; mon_on = 1'b0;
    repeat (4) @(negedge clk_i);
    cfg_i = w;
    stretch_amt = stretch;
  endtask

  task automatic go();
    mon_on = 1'b1;
    en_i   = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(drv == 1'b0, "R9", int'(drv), 0);
    chk(edg == 1'b0, "R9", int'(edg), 0);
    chk(sda_ok == 1'b0, "R9", int'(sda_ok), 0);

    // symmetric small dividers
    seg_start(mk(2, 3, 0, 0), 0);
    for (int i = 0; i < 3; i++) push_period(6, 7, 3, "R1", "R2", "R4");
    go(); drain();

    // asymmetric with exponent 2, hold 4
    seg_start(mk(5, 1, 2, 4), 0);
    for (int i = 0; i < 2; i++) push_period(24, 8, 7, "R1", "R2", "R4");
    go(); drain();

    // zero dividers: strobe lands on last low cycle
    seg_start(mk(0, 0, 3, 0), 0);
    for (int i = 0; i < 2; i++) push_period(4, 4, 3, "R1", "R2", "R5");
    go(); drain();

    // exponent clamp
    seg_start(mk(255, 255, 7, 0), 0);
    push_period(8164, 8164, 3, "R3", "R3", "R4");
    go(); drain();

    // hold longer than low phase: no strobe (R5)
    seg_start(mk(0, 1, 0, 10), 0);
    for (int i = 0; i < 2; i++) push_period(4, 5, -1, "R1/R5", "R2", "R5");
    go(); drain();

    // maximum hold field
    seg_start(mk(20, 2, 2, 63), 0);
    push_period(84, 12, 66, "R1", "R2", "R4");
    go(); drain();

    // clock stretching by 5 cycles
    seg_start(mk(2, 3, 0, 0), 5);
    for (int i = 0; i < 2; i++) push_period(6, 12, 3, "R1", "R7", "R4");
    go(); drain();

    // configuration change inside a low phase
    seg_start(mk(2, 3, 0, 0), 0);
    push_period(6, 7, 3, "R8", "R8", "R8");
    push_period(24, 8, 7, "R8", "R8", "R8");
    go();
    wait_fall();
    repeat (2) @(negedge clk_i);
    cfg_i = mk(5, 1, 2, 4);
    drain();

    // enable drop mid-low, then restart
    seg_start(mk(2, 3, 0, 0), 0);
    en_i = 1'b1;
    wait_fall();
    repeat (2) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(drv == 1'b0, "R9", int'(drv), 0);
    chk(edg == 1'b1, "R6", int'(edg), 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(drv == 1'b0 && edg == 1'b0 && sda_ok == 1'b0, "R9",
          int'({drv, edg, sda_ok}), 0);
    end
    push_period(6, 7, 3, "R10", "R2", "R4");
    go();
    @(negedge clk_i);
    chk(drv == 1'b1 && edg == 1'b1, "R10", int'({drv, edg}), 3);
    drain();

    repeat (4) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule